// File: doc/BRIEF.md
# Message-Based Interrupt Pin Assertion Decoder

This block lets bus peripherals raise interrupts by writing an interrupt number to one fixed memory location instead of driving interrupt wires. It watches a simple write port. A write is accepted when all of these hold: the strobe is high, the address is the target location, the feature enable is set, the number is in range, and the selected input is configured edge-triggered. An accepted write sets one bit in a request register. Each write stands for a single edge.

The lowest-numbered pending request is offered to a downstream message sender. The offer stays fixed until the sender acknowledges delivery. The acknowledgment clears that request bit, and the next pending request is offered.

Top module: `irq_pin_assert_dec`

## Requirements
- R1: After reset `req_o` is all zero and `pend_valid_o` is low.
- R2: A write with `wr_en_i` high, `wr_addr_i` = 32'hFEC0_0020, `feature_en_i` high, `wr_data_i[4:0]` = n < 24 and `edge_mode_i[n]` = 1 sets `req_o[n]`, visible after the clock edge that samples the write; `wr_data_i[31:5]` has no effect.
- R3: A write to any address other than 32'hFEC0_0020 changes no request bit.
- R4: While `feature_en_i` is low, writes change no request bit.
- R5: A decoded number from 24 to 31 changes no request bit.
- R6: A write to input n with `edge_mode_i[n]` = 0 (level mode) changes no request bit.
- R7: Whenever the offer is idle and some request bit is set after an edge, `pend_valid_o` is high after that edge, with `pend_idx_o` the lowest set bit. `pend_valid_o` is low only while `req_o` is zero.
- R8: While `pend_valid_o` is high and `ack_i` is low, `pend_idx_o` holds, even if a lower bit is set.
- R9: `ack_i` high while `pend_valid_o` is high clears `req_o[pend_idx_o]` at that edge, and the lowest remaining set bit is offered after the same edge.
- R10: If an accepted write and an acknowledgment hit the same bit in one cycle, the bit stays set and is offered again.
- R11: Writes on consecutive clocks are all taken, one per clock, with no backpressure.
- R12: `ack_i` while `pend_valid_o` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 32 | Write address |
| wr_data_i | input | 32 | Write data; bits 4:0 hold the interrupt number |
| feature_en_i | input | 1 | Enables decoding of message writes |
| edge_mode_i | input | 24 | Per-input trigger mode, 1 = edge |
| ack_i | input | 1 | Sender has delivered the offered interrupt |
| req_o | output | 24 | Request register |
| pend_valid_o | output | 1 | An interrupt is offered |
| pend_idx_o | output | 5 | Number of the offered interrupt |

## Verification
An accepted write shows in `req_o` after one clock edge, the edge that samples it. An idle offer picks up the new request at that same edge. An acknowledgment clears its bit and moves the offer to the next request within one edge as well. The bench drives inputs on the falling edge and checks the outputs at the next falling edge, exactly one rising edge later. It also checks after every cycle of a back-to-back burst, so no result is read a cycle early or late.

// File: rtl/irq_dec_pkg.sv
package irq_dec_pkg;
  localparam int unsigned IDX_W = 5;
  localparam logic [31:0] DEF_TARGET = 32'hFEC0_0020;
endpackage

// File: rtl/irq_wr_decode.sv
module irq_wr_decode
  import irq_dec_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 24,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned DATA_W  = 32,
  parameter logic [ADDR_W-1:0] TARGET = DEF_TARGET
) (
  input  logic               wr_en_i,
  input  logic               feature_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic [NUM_IRQ-1:0] edge_mode_i,
  output logic [NUM_IRQ-1:0] set_vec_o
);
  logic             hit;
  logic [IDX_W-1:0] num;

  assign hit = wr_en_i && feature_en_i && (wr_addr_i == TARGET);
  assign num = wr_data_i[IDX_W-1:0];

  // numbers with no matching lane never set anything
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_lane
    assign set_vec_o[i] = hit && edge_mode_i[i] && (num == IDX_W'(i));
  end
endmodule

// File: rtl/irq_req_bank.sv
module irq_req_bank #(
  parameter int unsigned NUM_IRQ = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] set_vec_i,
  input  logic [NUM_IRQ-1:0] clr_vec_i,
  output logic [NUM_IRQ-1:0] req_q_o,
  output logic [NUM_IRQ-1:0] req_d_o
);
  logic [NUM_IRQ-1:0] req_q;

  // set after clear: a colliding write wins
  assign req_d_o = (req_q & ~clr_vec_i) | set_vec_i;
  assign req_q_o = req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= '0;
    else         req_q <= req_d_o;
  end

  assert_write_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((set_vec_i & clr_vec_i) != '0) |=>
      ((req_q & $past(set_vec_i & clr_vec_i)) == $past(set_vec_i & clr_vec_i)));

  assert_set_lands_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_vec_i != '0) |=> ((req_q & $past(set_vec_i)) == $past(set_vec_i)));
endmodule

// File: rtl/irq_low_pick.sv
module irq_low_pick
  import irq_dec_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 24
) (
  input  logic [NUM_IRQ-1:0] vec_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   idx_o
);
  assign any_o = |vec_i;

  always_comb begin
    idx_o = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/irq_pin_assert_dec.sv
module irq_pin_assert_dec
  import irq_dec_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 24,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned DATA_W  = 32,
  parameter logic [ADDR_W-1:0] TARGET = DEF_TARGET
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic               feature_en_i,
  input  logic [NUM_IRQ-1:0] edge_mode_i,
  input  logic               ack_i,
  output logic [NUM_IRQ-1:0] req_o,
  output logic               pend_valid_o,
  output logic [IDX_W-1:0]   pend_idx_o
);
  logic [NUM_IRQ-1:0] set_vec, clr_vec, req_d;
  logic               pick_any, ack_fire, pend_valid_q;
  logic [IDX_W-1:0]   pick_idx, pend_idx_q;

  irq_wr_decode #(.NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TARGET(TARGET)) u_dec (
    .wr_en_i      (wr_en_i),
    .feature_en_i (feature_en_i),
    .wr_addr_i    (wr_addr_i),
    .wr_data_i    (wr_data_i),
    .edge_mode_i  (edge_mode_i),
    .set_vec_o    (set_vec)
  );

  assign ack_fire = ack_i && pend_valid_q;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_clr
    assign clr_vec[i] = ack_fire && (pend_idx_q == IDX_W'(i));
  end

  irq_req_bank #(.NUM_IRQ(NUM_IRQ)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_vec_i (set_vec),
    .clr_vec_i (clr_vec),
    .req_q_o   (req_o),
    .req_d_o   (req_d)
  );

  // pick from next-state so an acked bit is never re-offered stale
  irq_low_pick #(.NUM_IRQ(NUM_IRQ)) u_pick (
    .vec_i (req_d),
    .any_o (pick_any),
    .idx_o (pick_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_valid_q <= 1'b0;
      pend_idx_q   <= '0;
    end else if (!pend_valid_q || ack_fire) begin
      pend_valid_q <= pick_any;
      pend_idx_q   <= pick_idx;
    end
  end

  assign pend_valid_o = pend_valid_q;
  assign pend_idx_o   = pend_idx_q;

  assert_offer_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_valid_o && !ack_i) |=> (pend_valid_o && $stable(pend_idx_o)));

  assert_offer_backed_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_valid_o |-> req_o[pend_idx_o]);

  assert_idle_empty_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_valid_o |-> (req_o == '0));

  assert_no_set_when_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !feature_en_i |=> ((req_o & ~$past(req_o)) == '0));

  assert_no_set_other_addr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_addr_i != TARGET) |=> ((req_o & ~$past(req_o)) == '0));

  assert_idle_ack_noop_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend_valid_o && ack_i && !wr_en_i) |=> (req_o == '0));
endmodule

// File: tb/irq_pin_assert_dec_tb_top.sv
module irq_pin_assert_dec_tb_top;
  localparam int N = 24;
  localparam logic [31:0] TGT = 32'hFEC0_0020;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [31:0]   wr_addr_i = '0;
  logic [31:0]   wr_data_i = '0;
  logic          feature_en_i = 1'b0;
  logic [N-1:0]  edge_mode_i = '1;
  logic          ack_i = 1'b0;
  logic [N-1:0]  req_o;
  logic          pend_valid_o;
  logic [4:0]    pend_idx_o;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [N-1:0] mdl = '0;

  always #5 clk_i = ~clk_i;

  irq_pin_assert_dec dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .feature_en_i(feature_en_i), .edge_mode_i(edge_mode_i),
    .ack_i(ack_i), .req_o(req_o), .pend_valid_o(pend_valid_o), .pend_idx_o(pend_idx_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic int lowest(input logic [N-1:0] v);
    for (int i = N - 1; i >= 0; i--) if (v[i]) lowest = i;
    if (v == '0) lowest = -1;
  endfunction

  // drive one write for one cycle; caller checks at the returned negedge
  task automatic wr(input logic [31:0] addr, input int n);
    wr_en_i   = 1'b1;
    wr_addr_i = addr;
    wr_data_i = {27'h4D3C2B1, 5'(n)};
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic drain(input string tag);
    int e;
    while (mdl != '0) begin
      e = lowest(mdl);
      chk(pend_valid_o && pend_idx_o == 5'(e), tag, {26'd0, pend_valid_o, pend_idx_o}, {26'd0, 1'b1, 5'(e)});
      ack_i = 1'b1;
      @(negedge clk_i);
      ack_i = 1'b0;
      mdl[e] = 1'b0;
      chk(req_o == mdl, "R9 clear", 32'(req_o), 32'(mdl));
    end
    chk(!pend_valid_o, "R7 idle after drain", 32'(pend_valid_o), 32'd0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(req_o == '0 && !pend_valid_o, "R1 reset", {7'd0, pend_valid_o, req_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2 R5 R8 R11: back-to-back descending sweep, first accepted is 23
    feature_en_i = 1'b1;
    edge_mode_i  = '1;
    wr_en_i = 1'b1;
    for (int n = 31; n >= 0; n--) begin
      wr_addr_i = TGT;
      wr_data_i = {27'h4D3C2B1, 5'(n)};
      @(negedge clk_i);
      if (n < N) mdl[n] = 1'b1;
      chk(req_o == mdl, n < N ? "R2 R11 set" : "R5 out of range", 32'(req_o), 32'(mdl));
      if (mdl != '0)
        chk(pend_valid_o && pend_idx_o == 5'd23, "R8 hold", 32'(pend_idx_o), 32'd23);
    end
    wr_en_i = 1'b0;
    chk(pend_valid_o && pend_idx_o == 5'd23, "R7 first offer", 32'(pend_idx_o), 32'd23);
    ack_i = 1'b1;
    @(negedge clk_i);
    ack_i = 1'b0;
    mdl[23] = 1'b0;
    chk(req_o == mdl, "R9 clear 23", 32'(req_o), 32'(mdl));
    drain("R9 R7 next lowest");

    // R4: feature disabled
    feature_en_i = 1'b0;
    for (int n = 0; n < 32; n++) begin
      wr(TGT, n);
      chk(req_o == '0, "R4 disabled", 32'(req_o), 32'd0);
    end
    feature_en_i = 1'b1;

    // R3: single-bit address corruptions
    for (int b = 0; b < 32; b++) begin
      wr(TGT ^ (32'd1 << b), b % N);
      chk(req_o == '0, "R3 other addr", 32'(req_o), 32'd0);
    end

    // R6: mixed trigger modes
    edge_mode_i = 24'h5A5A5A;
    for (int n = 0; n < N; n++) begin
      wr(TGT, n);
      if (edge_mode_i[n]) mdl[n] = 1'b1;
      chk(req_o == mdl, "R6 mode gate", 32'(req_o), 32'(mdl));
    end
    drain("R6 R9 drain");
    edge_mode_i = '1;

    // R12: ack while idle
    ack_i = 1'b1;
    @(negedge clk_i);
    ack_i = 1'b0;
    chk(req_o == '0 && !pend_valid_o, "R12 idle ack", {7'd0, pend_valid_o, req_o}, 32'd0);

    // R10: collision on bit 3
    wr(TGT, 3);
    mdl[3] = 1'b1;
    chk(pend_valid_o && pend_idx_o == 5'd3, "R7 offer 3", 32'(pend_idx_o), 32'd3);
    ack_i = 1'b1;
    wr(TGT, 3);
    ack_i = 1'b0;
    chk(req_o == mdl, "R10 write wins", 32'(req_o), 32'(mdl));
    chk(pend_valid_o && pend_idx_o == 5'd3, "R10 reoffer", 32'(pend_idx_o), 32'd3);
    drain("R10 drain");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule